// File: doc/BRIEF.md
# Predicated Conditional Result Writeback Gate

This block sits at the tail of a vector element pipeline and decides, one element per cycle, what reaches the register files. For each element it takes the operation result, an overflow flag, the element's predicate bit and the per-instruction controls. These controls are a condition-bit selector with its invert flag, a record flag, a compare-only flag and a zeroing flag. From the result it forms a four-bit condition field. It then drives two independent write ports: one for the destination register file and one for the condition register file.

The condition field may be stored even when the test cancels the result write. This lets later code inspect which elements failed. In compare-only mode the arithmetic result is never stored, so the operation acts as a compare that only produces condition fields. An internal element counter numbers the elements. A start pulse restarts the counter at zero and each valid element advances it. The write indices are the supplied base indices plus the element number.

Top module: `predwb_gate`

## Requirements
- R1: After reset both write enables are low, and the element counter is zero so that the first element uses the base indices.
- R2: An element with predicate bit 0 and zeroing off produces no register write and no condition write.
- R3: An element with predicate bit 0, zeroing on and compare-only off produces a register write of all zeros, and no condition write.
- R4: An element with predicate bit 1 writes its condition field whenever the record flag or the compare-only flag is 1, whatever the test outcome. The field is {lt,gt,eq,so} in bits 3..0. Here lt means the result is negative as a signed value, gt means it is positive, eq means it is zero, and so is the overflow input.
- R5: The selector picks one condition bit: 0 is lt, 1 is gt, 2 is eq, 3 is so. The test passes when the selected bit differs from the invert flag. A passing element with predicate 1 and compare-only 0 writes its result.
- R6: An element with predicate 1 that fails the test writes nothing to the register file when zeroing is off, and writes all zeros when zeroing is on (compare-only 0).
- R7: With compare-only set, no register write of any kind happens, including zero writes.
- R8: Element i writes register index reg_base+i and condition index cr_base+i, each taken modulo the index width. A start pulse makes the current element number 0. Each valid element advances the number by one.
- R9: Writes appear exactly one cycle after the valid element is presented. A cycle without valid produces no writes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Restart element numbering at this cycle |
| valid_i | input | 1 | An element is presented this cycle |
| result_i | input | XLEN | Operation result for the element |
| ovf_i | input | 1 | Overflow/saturation flag for the element |
| pred_i | input | 1 | Predicate bit of the element |
| sel_i | input | 2 | Condition bit selector |
| inv_i | input | 1 | Invert the test sense |
| rc_i | input | 1 | Record condition field |
| cmp_only_i | input | 1 | Compare-only mode |
| zero_i | input | 1 | Zeroing flag (drives source and destination zeroing alike) |
| reg_base_i | input | REG_W | Destination register base index |
| cr_base_i | input | CR_W | Condition register base index |
| reg_we_o | output | 1 | Register write enable |
| reg_idx_o | output | REG_W | Register write index |
| reg_wdata_o | output | XLEN | Register write data |
| cr_we_o | output | 1 | Condition field write enable |
| cr_idx_o | output | CR_W | Condition field write index |
| cr_wdata_o | output | 4 | Condition field write data |

## Verification
The two functions that meet in one cycle are the condition-field store and the cancellation or zeroing of the result write for the same element. The bench provokes this with random elements that set the record flag while the selected bit fails the test, under both zeroing settings and with compare-only mixed in. In each output cycle it judges both ports against a reference model: the condition port must carry the field, and the register port must be silent or carry zero as the requirements dictate.

// File: rtl/predwb_pkg.sv
package predwb_pkg;

    typedef enum logic [1:0] {
        SEL_LT = 2'd0,
        SEL_GT = 2'd1,
        SEL_EQ = 2'd2,
        SEL_SO = 2'd3
    } cond_sel_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    localparam int unsigned COND_W = 4;

endpackage

// File: rtl/predwb_cond_gen.sv
module predwb_cond_gen
    import predwb_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] result_i,
    input  logic            ovf_i,
    output cond_t           cond_o
);

    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (result_i == '0);
        is_neg  = result_i[XLEN-1];
        cond_o.lt = is_neg;
        cond_o.gt = !is_neg && !is_zero;
        cond_o.eq = is_zero;
        cond_o.so = ovf_i;
    end

    // R4: the three sign flags are mutually exclusive and one is always set
    always_comb begin
        a_cond_onehot_r4: assert ($countones({cond_o.lt, cond_o.gt, cond_o.eq}) == 1 || $isunknown(result_i));
    end

endmodule

// File: rtl/predwb_cond_test.sv
module predwb_cond_test
    import predwb_pkg::*;
(
    input  cond_t      cond_i,
    input  logic [1:0] sel_i,
    input  logic       inv_i,
    output logic       pass_o
);

    logic [COND_W-1:0] bits;
    logic              picked;

    always_comb begin
        bits = cond_i;
        unique case (cond_sel_e'(sel_i))
            SEL_LT:  picked = cond_i.lt;
            SEL_GT:  picked = cond_i.gt;
            SEL_EQ:  picked = cond_i.eq;
            default: picked = cond_i.so;
        endcase
        pass_o = picked ^ inv_i;
    end

    // R5: with inv clear, a pass always means the picked bit was set
    always_comb begin
        a_pass_bit_r5: assert (!(pass_o && !inv_i) || bits[COND_W-1-sel_i] || $isunknown(sel_i));
    end

endmodule

// File: rtl/predwb_elem_ctr.sv
module predwb_elem_ctr #(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_d, st_q;
    logic [IDX_W-1:0] cur_idx;

    always_comb begin
        cur_idx = start_i ? '0 : st_q.cnt;
        st_d    = st_q;
        if (adv_i) begin
            st_d.cnt = cur_idx + 1'b1;
        end else if (start_i) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_o = cur_idx;

    // R8: an element without restart advances the count by one
    p_ctr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !start_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R8: a restart with an element leaves the count at one
    p_ctr_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && start_i) |=> (st_q.cnt == IDX_W'(1)));

endmodule

// File: rtl/predwb_gate.sv
module predwb_gate
    import predwb_pkg::*;
#(
    parameter int unsigned XLEN  = 64,
    parameter int unsigned REG_W = 7,
    parameter int unsigned CR_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             valid_i,
    input  logic [XLEN-1:0]  result_i,
    input  logic             ovf_i,
    input  logic             pred_i,
    input  logic [1:0]       sel_i,
    input  logic             inv_i,
    input  logic             rc_i,
    input  logic             cmp_only_i,
    input  logic             zero_i,
    input  logic [REG_W-1:0] reg_base_i,
    input  logic [CR_W-1:0]  cr_base_i,
    output logic             reg_we_o,
    output logic [REG_W-1:0] reg_idx_o,
    output logic [XLEN-1:0]  reg_wdata_o,
    output logic             cr_we_o,
    output logic [CR_W-1:0]  cr_idx_o,
    output logic [COND_W-1:0] cr_wdata_o
);

    localparam int unsigned IDX_W = (REG_W > CR_W) ? REG_W : CR_W;

    typedef struct packed {
        logic              reg_we;
        logic [REG_W-1:0]  reg_idx;
        logic [XLEN-1:0]   reg_wdata;
        logic              cr_we;
        logic [CR_W-1:0]   cr_idx;
        logic [COND_W-1:0] cr_wdata;
    } wb_state_t;

    wb_state_t st_d, st_q;

    cond_t            cond;
    logic             pass;
    logic [IDX_W-1:0] elem_idx;
    logic             dst_zero;
    logic             src_zero;

    predwb_cond_gen #(.XLEN(XLEN)) u_cond_gen (
        .result_i (result_i),
        .ovf_i    (ovf_i),
        .cond_o   (cond)
    );

    predwb_cond_test u_cond_test (
        .cond_i (cond),
        .sel_i  (sel_i),
        .inv_i  (inv_i),
        .pass_o (pass)
    );

    predwb_elem_ctr #(.IDX_W(IDX_W)) u_elem_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .adv_i   (valid_i),
        .idx_o   (elem_idx)
    );

    always_comb begin
        // one zeroing flag drives both zeroing controls
        dst_zero = zero_i;
        src_zero = zero_i;

        st_d           = st_q;
        st_d.reg_we    = 1'b0;
        st_d.cr_we     = 1'b0;
        st_d.reg_idx   = reg_base_i + REG_W'(elem_idx);
        st_d.cr_idx    = cr_base_i + CR_W'(elem_idx);
        st_d.cr_wdata  = cond;
        st_d.reg_wdata = result_i;

        if (valid_i) begin
            if (pred_i) begin
                st_d.cr_we = rc_i || cmp_only_i;
                if (!cmp_only_i) begin
                    if (pass) begin
                        st_d.reg_we = 1'b1;
                    end else if (dst_zero) begin
                        st_d.reg_we    = 1'b1;
                        st_d.reg_wdata = '0;
                    end
                end
            end else if ((dst_zero || src_zero) && !cmp_only_i) begin
                st_d.reg_we    = 1'b1;
                st_d.reg_wdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_we_o    = st_q.reg_we;
    assign reg_idx_o   = st_q.reg_idx;
    assign reg_wdata_o = st_q.reg_wdata;
    assign cr_we_o     = st_q.cr_we;
    assign cr_idx_o    = st_q.cr_idx;
    assign cr_wdata_o  = st_q.cr_wdata;

    // R9: an idle cycle yields no writes in the next cycle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!reg_we_o && !cr_we_o));

    // R2: masked element never stores a condition field
    p_mask_no_cr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !pred_i) |=> !cr_we_o);

    // R7: compare-only never touches the register file
    p_cmp_no_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && cmp_only_i) |=> !reg_we_o);

    // R4: active element with record or compare-only stores its field
    p_cr_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i && (rc_i || cmp_only_i)) |=> cr_we_o);

    // R3: masked element under zeroing writes zero
    p_mask_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !pred_i && zero_i && !cmp_only_i) |=> (reg_we_o && reg_wdata_o == '0));

    // R6: failing element without zeroing stays silent on the register port
    p_fail_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && pred_i && !pass && !zero_i) |=> !reg_we_o);

endmodule

// File: tb/predwb_gate_tb.sv
module predwb_gate_tb;

    localparam int unsigned XLEN  = 64;
    localparam int unsigned REG_W = 7;
    localparam int unsigned CR_W  = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i, valid_i, ovf_i, pred_i, inv_i, rc_i, cmp_only_i, zero_i;
    logic [XLEN-1:0]  result_i;
    logic [1:0]       sel_i;
    logic [REG_W-1:0] reg_base_i;
    logic [CR_W-1:0]  cr_base_i;
    logic             reg_we_o, cr_we_o;
    logic [REG_W-1:0] reg_idx_o;
    logic [XLEN-1:0]  reg_wdata_o;
    logic [CR_W-1:0]  cr_idx_o;
    logic [3:0]       cr_wdata_o;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    int unsigned elem_n  = 0;
    bit          done    = 1'b0;

    always #10 clk = ~clk;

    predwb_gate #(.XLEN(XLEN), .REG_W(REG_W), .CR_W(CR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .result_i(result_i), .ovf_i(ovf_i), .pred_i(pred_i), .sel_i(sel_i),
        .inv_i(inv_i), .rc_i(rc_i), .cmp_only_i(cmp_only_i), .zero_i(zero_i),
        .reg_base_i(reg_base_i), .cr_base_i(cr_base_i),
        .reg_we_o(reg_we_o), .reg_idx_o(reg_idx_o), .reg_wdata_o(reg_wdata_o),
        .cr_we_o(cr_we_o), .cr_idx_o(cr_idx_o), .cr_wdata_o(cr_wdata_o)
    );

    function automatic logic [3:0] exp_cond(input logic [XLEN-1:0] r, input logic ov);
        logic lt, gt, eq;
        lt = $signed(r) < 0;
        gt = $signed(r) > 0;
        eq = (r == '0);
        return {lt, gt, eq, ov};
    endfunction

    function automatic logic exp_pass(input logic [3:0] c, input logic [1:0] s, input logic iv);
        return c[3 - s] != iv;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Drive one element at a negedge, check outputs at the following negedge.
    task automatic elem(input bit st, input bit vld, input logic [XLEN-1:0] res, input bit ov,
                        input bit pr, input logic [1:0] s, input bit iv, input bit rc,
                        input bit cmp, input bit zz, input string req);
        logic [3:0] c;
        bit ps, e_reg, e_cr, e_zero;
        int unsigned idx;
        start_i = st; valid_i = vld; result_i = res; ovf_i = ov; pred_i = pr;
        sel_i = s; inv_i = iv; rc_i = rc; cmp_only_i = cmp; zero_i = zz;
        if (st) elem_n = 0;
        idx = elem_n;
        if (vld) elem_n++;
        c  = exp_cond(res, ov);
        ps = exp_pass(c, s, iv);
        e_cr = vld && pr && (rc || cmp);
        e_reg = 1'b0; e_zero = 1'b0;
        if (vld && !cmp) begin
            if (pr && ps) e_reg = 1'b1;
            else if (zz) begin e_reg = 1'b1; e_zero = 1'b1; end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, "reg_we", 64'(reg_we_o), 64'(e_reg));
        check(req, "cr_we",  64'(cr_we_o),  64'(e_cr));
        if (e_reg) begin
            check(req, "reg_wdata", reg_wdata_o, e_zero ? 64'd0 : res);
            check("R8", "reg_idx", 64'(reg_idx_o), 64'(REG_W'(reg_base_i + REG_W'(idx))));
        end
        if (e_cr) begin
            check("R4", "cr_wdata", 64'(cr_wdata_o), 64'(c));
            check("R8", "cr_idx", 64'(cr_idx_o), 64'(CR_W'(cr_base_i + CR_W'(idx))));
        end
        valid_i = 1'b0; start_i = 1'b0;
    endtask

    initial begin
        for (int w = 0; w < 20000; w++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; start_i = 0; valid_i = 0; result_i = '0; ovf_i = 0; pred_i = 0;
        sel_i = 0; inv_i = 0; rc_i = 0; cmp_only_i = 0; zero_i = 0;
        reg_base_i = 7'd10; cr_base_i = 7'd3;
        repeat (3) @(negedge clk);
        check("R1", "reg_we reset", 64'(reg_we_o), 64'd0);
        check("R1", "cr_we reset",  64'(cr_we_o),  64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first element after reset without start uses index 0
        elem(0, 1, 64'd5, 0, 1, 2'd1, 0, 1, 0, 0, "R1");
        // R9: idle cycle
        elem(0, 0, 64'd5, 0, 1, 2'd1, 0, 1, 0, 1, "R9");
        // R2: masked, no zeroing
        elem(1, 1, 64'd7, 0, 0, 2'd1, 0, 1, 0, 0, "R2");
        // R3: masked with zeroing
        elem(0, 1, 64'd7, 0, 0, 2'd1, 0, 1, 0, 1, "R3");
        // R5: each selector, pass
        elem(0, 1, -64'sd3, 0, 1, 2'd0, 0, 0, 0, 0, "R5");
        elem(0, 1, 64'd9,   0, 1, 2'd1, 0, 0, 0, 0, "R5");
        elem(0, 1, 64'd0,   0, 1, 2'd2, 0, 0, 0, 0, "R5");
        elem(0, 1, 64'd4,   1, 1, 2'd3, 0, 0, 0, 0, "R5");
        elem(0, 1, 64'd4,   0, 1, 2'd2, 1, 0, 0, 0, "R5");
        // R6: fail, record on, zeroing off then on (cr stored in same cycle)
        elem(0, 1, 64'd4, 0, 1, 2'd2, 0, 1, 0, 0, "R6");
        elem(0, 1, 64'd4, 0, 1, 2'd2, 0, 1, 0, 1, "R6");
        // R7: compare-only pass, masked+zero, fail+zero
        elem(0, 1, 64'd0, 0, 1, 2'd2, 0, 0, 1, 0, "R7");
        elem(0, 1, 64'd0, 0, 0, 2'd2, 0, 0, 1, 1, "R7");
        elem(0, 1, 64'd3, 0, 1, 2'd2, 0, 0, 1, 1, "R7");
        // R8: index wrap
        reg_base_i = 7'd126; cr_base_i = 7'd127;
        elem(1, 1, 64'd1, 0, 1, 2'd1, 0, 1, 0, 0, "R8");
        elem(0, 1, 64'd1, 0, 1, 2'd1, 0, 1, 0, 0, "R8");
        elem(0, 1, 64'd1, 0, 1, 2'd1, 0, 1, 0, 0, "R8");
        // random mix
        for (int k = 0; k < 400; k++) begin
            logic [XLEN-1:0] r;
            int unsigned kind;
            kind = $urandom_range(0, 3);
            case (kind)
                0: r = '0;
                1: r = 64'($urandom_range(1, 50));
                2: r = -64'($urandom_range(1, 50));
                default: r = {$urandom(), $urandom()};
            endcase
            if ($urandom_range(0, 9) == 0) begin
                reg_base_i = 7'($urandom());
                cr_base_i  = 7'($urandom());
            end
            elem($urandom_range(0, 15) == 0, $urandom_range(0, 4) != 0, r,
                 1'($urandom()), 1'($urandom()), 2'($urandom()), 1'($urandom()),
                 1'($urandom()), $urandom_range(0, 3) == 0, 1'($urandom()), "R6");
        end
        finish_run();
    end

endmodule